// File: doc/BRIEF.md
# Comparator Trip Qualification Filter

This block turns a raw comparator output into a timed shutdown request for a PWM stage. The comparator level arrives asynchronously and is first brought into the system clock domain through a short flip-flop chain. While the synchronised level stays high, a small counter advances once per filter tick, where a tick is a single-cycle clock enable from a slower time base. When the count reaches a programmed 4-bit delay, the shutdown output asserts. If the comparator drops before that point, the count is discarded. A short spike therefore never reaches the power stage.

A mode input picks what happens after a trip. In release mode the shutdown follows the comparator back down. In hold mode it stays asserted until a clear pulse arrives. A separate status output gives the synchronised comparator level, re-sampled on the system clock, so it can be read at any time.

Top module: `trip_delay_filter`

## Requirements
- R1: While reset is held and on the first sample after its release, `pwm_off` and `cmp_status` are both 0.
- R2: `cmp_status` equals the value `cmp_in` had exactly three clock edges earlier. Two edges come from synchronisation and one from sampling.
- R3: With `delay_sel` = D, the comparator synchronised high and the filter idle, `pwm_off` stays 0 through the first D cycles in which `tick` = 1. It becomes 1 on the clock edge that samples the (D+1)-th such cycle, however many idle cycles lie between ticks.
- R4: With `delay_sel` = 0, the first tick after the synchronised comparator goes high asserts `pwm_off`.
- R5: If the synchronised comparator falls before the count reaches D, the count is cleared and no shutdown is issued. The next rise again needs D+1 ticks.
- R6: Ticks that arrive while the synchronised comparator is low do not advance the count.
- R7: With `latch_mode` = 0 (release mode), an asserted `pwm_off` returns to 0 on the third clock edge after `cmp_in` falls.
- R8: With `latch_mode` = 1 (hold mode), `pwm_off` stays 1 after the comparator falls. It returns to 0 on the edge that samples `clear_latch` = 1.
- R9: With `latch_mode` = 0, `clear_latch` has no effect: an asserted `pwm_off` stays 1 while the comparator stays high.
- R10: After a clear in hold mode with the comparator still high, shutdown asserts again only after another D+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Raw comparator level, asynchronous |
| tick | input | 1 | Filter clock enable, one cycle wide |
| delay_sel | input | 4 | Qualification delay in ticks (D) |
| latch_mode | input | 1 | 1 = hold shutdown until cleared, 0 = release with comparator |
| clear_latch | input | 1 | Clear pulse for a held shutdown |
| pwm_off | output | 1 | Qualified shutdown request |
| cmp_status | output | 1 | Synchronised comparator level, re-sampled |

## Verification
The bench sweeps every delay value in both modes. It uses two tick cadences: back-to-back ticks and ticks separated by idle cycles. This separates counting ticks from counting clock cycles and exposes off-by-one errors at each delay. Several interrupted patterns follow. A comparator drop one tick short of the trip shows whether the count is really cleared. Ticks given while the comparator is low show whether they are ignored. A clear pulse is given in both modes, with the comparator high, to separate hold behaviour from release behaviour. A requalification after a clear shows that the count restarts from zero.

// File: rtl/trip_delay_filter.sv
module trip_delay_filter #(
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  input  logic             tick,
  input  logic [DLY_W-1:0] delay_sel,
  input  logic             latch_mode,
  input  logic             clear_latch,
  output logic             pwm_off,
  output logic             cmp_status
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DLY_W-1:0]       cnt_q;
  logic                   off_q;
  logic                   stat_q;

  wire cmp_s  = sync_q[SYNC_STAGES-1];
  wire clr    = latch_mode & clear_latch;
  wire match  = tick & cmp_s & ~off_q & (cnt_q == delay_sel);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       cnt_q <= '0;
    else if (!cmp_s || clr)           cnt_q <= '0;
    else if (tick && !off_q && !match) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    off_q <= 1'b0;
    else if (clr)                  off_q <= 1'b0;
    else if (match)                off_q <= 1'b1;
    else if (!latch_mode && !cmp_s) off_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= cmp_s;

  assign pwm_off    = off_q;
  assign cmp_status = stat_q;

endmodule

// File: rtl/trip_delay_filter_chk.sv
module trip_delay_filter_chk #(
  parameter int LAT = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cmp_in,
  input logic tick,
  input logic latch_mode,
  input logic clear_latch,
  input logic pwm_off,
  input logic cmp_status
);

  logic [LAT-1:0] hist;
  logic [3:0]     age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist <= '0;
      age  <= '0;
    end else begin
      hist <= {hist[LAT-2:0], cmp_in};
      if (age != 4'hF) age <= age + 1'b1;
    end

  assert_status_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age > LAT) |-> (cmp_status == hist[LAT-1]));

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_off) |-> ($past(tick) && cmp_status));

  assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_off) |-> (!$past(latch_mode) || $past(clear_latch)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && pwm_off && !clear_latch) |=> pwm_off);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && clear_latch) |=> !pwm_off);

endmodule

bind trip_delay_filter trip_delay_filter_chk chk_i (.*);

// File: tb/trip_delay_filter_test.sv
module trip_delay_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] delay_sel = 4'd0;
  logic       latch_mode = 1'b0;
  logic       clear_latch = 1'b0;
  logic       pwm_off;
  logic       cmp_status;
  int         runs = 0;
  int         fails = 0;

  always #2 clk = ~clk;

  trip_delay_filter uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .tick(tick),
    .delay_sel(delay_sel), .latch_mode(latch_mode), .clear_latch(clear_latch),
    .pwm_off(pwm_off), .cmp_status(cmp_status)
  );

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(logic got, logic exp, string req);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (D=%0d mode=%0b)", req, got, exp, delay_sel, latch_mode);
    end
  endtask

  task automatic pulse_tick(int gap);
    tick = 1'b1;
    step();
    tick = 1'b0;
    step(gap);
  endtask

  task automatic pulse_clear();
    clear_latch = 1'b1;
    step();
    clear_latch = 1'b0;
  endtask

  task automatic quiesce();
    cmp_in = 1'b0;
    step(4);
    pulse_clear();
    step();
  endtask

  task automatic sweep(int d, logic mode, int gap);
    latch_mode = mode;
    quiesce();
    delay_sel = 4'(d);
    cmp_in = 1'b1;
    step(3);
    for (int k = 1; k <= d + 2; k++) begin
      pulse_tick(gap);
      chk(pwm_off, (k >= d + 1), (d == 0) ? "R4" : "R3");
    end
    cmp_in = 1'b0;
    if (mode) begin
      step(5);
      chk(pwm_off, 1'b1, "R8 hold");
      pulse_clear();
      chk(pwm_off, 1'b0, "R8 clear");
    end else begin
      step(2);
      chk(pwm_off, 1'b1, "R7 before release");
      step();
      chk(pwm_off, 1'b0, "R7 release");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    step(3);
    chk(pwm_off, 1'b0, "R1 pwm_off in reset");
    chk(cmp_status, 1'b0, "R1 status in reset");
    rst_n = 1'b1;
    step();
    chk(pwm_off, 1'b0, "R1 pwm_off after reset");
    chk(cmp_status, 1'b0, "R1 status after reset");

    // R2: status latency of three edges
    cmp_in = 1'b1;
    step(2);
    chk(cmp_status, 1'b0, "R2 rise edge2");
    step();
    chk(cmp_status, 1'b1, "R2 rise edge3");
    cmp_in = 1'b0;
    step(2);
    chk(cmp_status, 1'b1, "R2 fall edge2");
    step();
    chk(cmp_status, 1'b0, "R2 fall edge3");

    // R3/R4/R7/R8: full delay sweep, both modes, two tick cadences
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 3; g += 2)
        for (int d = 0; d < 16; d++)
          sweep(d, m[0], g);

    // R5: drop one tick short, then requalify
    for (int m = 0; m < 2; m++) begin
      latch_mode = m[0];
      quiesce();
      delay_sel = 4'd5;
      cmp_in = 1'b1;
      step(3);
      for (int k = 0; k < 5; k++) pulse_tick(1);
      chk(pwm_off, 1'b0, "R5 short of match");
      cmp_in = 1'b0;
      step(4);
      chk(pwm_off, 1'b0, "R5 no shutdown after drop");
      cmp_in = 1'b1;
      step(3);
      for (int k = 0; k < 5; k++) pulse_tick(0);
      chk(pwm_off, 1'b0, "R5 count restarted");
      pulse_tick(0);
      chk(pwm_off, 1'b1, "R5 trip after full count");
    end

    // R6: ticks while comparator low are ignored
    latch_mode = 1'b0;
    quiesce();
    delay_sel = 4'd2;
    for (int k = 0; k < 6; k++) pulse_tick(0);
    chk(pwm_off, 1'b0, "R6 no trip while low");
    cmp_in = 1'b1;
    step(3);
    pulse_tick(0);
    pulse_tick(0);
    chk(pwm_off, 1'b0, "R6 low ticks not counted");
    pulse_tick(0);
    chk(pwm_off, 1'b1, "R6 trip after three ticks");

    // R9: clear ignored in release mode
    pulse_clear();
    step();
    chk(pwm_off, 1'b1, "R9 clear ignored");
    step(3);
    chk(pwm_off, 1'b1, "R9 still asserted");

    // R10: clear with comparator high requires full requalification
    latch_mode = 1'b1;
    quiesce();
    delay_sel = 4'd3;
    cmp_in = 1'b1;
    step(3);
    for (int k = 0; k < 4; k++) pulse_tick(0);
    chk(pwm_off, 1'b1, "R10 first trip");
    pulse_clear();
    chk(pwm_off, 1'b0, "R10 cleared while high");
    for (int k = 0; k < 3; k++) pulse_tick(1);
    chk(pwm_off, 1'b0, "R10 not yet requalified");
    pulse_tick(1);
    chk(pwm_off, 1'b1, "R10 requalified");

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule